// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM with 1,024 rows alive. After reset it waits out the power-up pause. It then runs a wake-up burst of CAS-before-RAS (CBR) refresh cycles, and only after that does it declare the memory ready. In normal operation an interval timer adds one owed refresh to a debt counter on each period. While anything is owed, the block asks an access arbiter for the bus. Once the arbiter grants the bus and the page is closed, the block runs one CBR cycle for each owed refresh. The block never supplies a row address: the device's internal row counter does the addressing.

On request, the block parks the memory in self refresh. It starts a CBR cycle, holds both strobes low for at least the minimum self-refresh time, and keeps them low until the request is withdrawn. On exit it holds RAS# high for the exit precharge time. It then runs a catch-up burst, clears the debt and restarts the interval.

Every timing value is given in nanoseconds and turned into a clock-cycle count at elaboration, rounded up from the clock period. While the block does not own the bus it holds all strobes high.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ready`, `refReq`, `refUrgent` and `busOwned` are 0 and `rasN`, `casLN` and `casHN` are 1. RAS# then stays high for at least the power-up wait (PWR cycles) before the first CBR cycle.
- R2: Once the power-up wait ends, exactly WAKE_CNT (default 8) CBR cycles are issued without a grant, and only then does `ready` go to 1. Before that, `refReq` and `refUrgent` stay 0.
- R3: In every refresh cycle both CAS# lanes are low in the cycle before RAS# falls and in the cycle in which it falls. WE# is high whenever RAS# falls.
- R4: Each refresh holds RAS# low for at least max(tRAS, tCHR) in cycles. Between refresh cycles RAS# stays high for at least max(tRP, tRC minus that low time).
- R5: Once ready, one refresh becomes owed every INT cycles. `refReq` goes to 1 about INT cycles after `ready` rises, and stays 1 while the block is idle and owes refreshes.
- R6: A refresh starts only in the cycle after `refGrant` and `pageClosed` are both sampled at 1 while `refReq` is 1. `busOwned` stays 0 while `pageClosed` is 0. Each granted refresh performs one CBR cycle and pays off one owed refresh.
- R7: The debt saturates at DEBT_MAX (default 8) and a tick arriving at the limit is dropped. `refUrgent` is 1 exactly while the debt equals DEBT_MAX. After saturation, draining takes exactly DEBT_MAX cycles.
- R8: While `selfRefReq` is 1, `refReq` is 1 in idle. A grant then starts a CBR cycle that holds RAS# and both CAS# low. `inSelfRef` rises no sooner than tRASS cycles after the bus is taken, and while it is 1 all strobes are low.
- R9: After `selfRefReq` falls, and once tRASS is met, RAS# stays high for at least tRPS cycles. Then exactly WAKE_CNT catch-up CBR cycles run, the bus is released and the debt is cleared (`refReq` 0).
- R10: Once `ready` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Arbiter grants the bus to the scheduler |
| pageClosed | input | 1 | No page is open on the memory |
| selfRefReq | input | 1 | Hold high to enter and stay in self refresh |
| refReq | output | 1 | Scheduler wants the bus |
| refUrgent | output | 1 | Debt at its limit; arbiter should preempt accesses |
| busOwned | output | 1 | Scheduler is driving the strobes |
| ready | output | 1 | Wake-up sequence complete |
| inSelfRef | output | 1 | Memory is in self refresh |
| rasN | output | 1 | Row strobe, active low |
| casLN | output | 1 | Low-lane column strobe, active low |
| casHN | output | 1 | High-lane column strobe, active low |
| weN | output | 1 | Write enable, active low (held high) |

## Verification
The bench counts CBR cycles against an expected queue at every RAS# falling edge. It therefore catches a wake-up burst of the wrong length, a ready flag raised too early, and a refresh started without a grant or with the page still open, because each of these shows up as a missing or unexpected refresh. It lets the debt run past its limit and then drains it. A counter that wrapped, or that kept the dropped ticks, would produce a refresh count other than eight. It also exercises self refresh. A scheduler that released RAS# before tRASS, skipped the exit precharge or the catch-up burst, or left the debt standing would show up as a short strobe interval, a short burst or a request left raised after exit.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    S_PWR, S_IDLE, S_CSET, S_RLOW, S_PRE, S_SRHOLD, S_SREXIT
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   ldTimer;
    state_t ldSel;
    logic   ldBurstFull;
    logic   ldBurstOne;
    logic   decBurst;
    logic   decDebt;
    logic   clrDebt;
    logic   runInt;
    logic   rstInt;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerDone;
    logic chrActive;
    logic burstLast;
    logic debtNz;
    logic debtFull;
  } status_t;

  function automatic int nsToCyc(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_dp.sv
module dram_ref_dp
  import dram_ref_pkg::*;
#(
  parameter int PWR_C    = 10000,
  parameter int CSR_C    = 1,
  parameter int RASL_C   = 5,
  parameter int CHR_C    = 1,
  parameter int PRE_C    = 4,
  parameter int RASS_C   = 10000,
  parameter int RPS_C    = 9,
  parameter int INT_C    = 1560,
  parameter int WAKE_CNT = 8,
  parameter int DEBT_MAX = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  state_t  state,
  output status_t sts,
  output logic    rasN,
  output logic    casLN,
  output logic    casHN,
  output logic    weN
);
  localparam int TMAX = maxOf(maxOf(PWR_C, RASS_C), maxOf(maxOf(RPS_C, CSR_C), maxOf(RASL_C, PRE_C)));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(INT_C + 1);
  localparam int BW   = $clog2(WAKE_CNT + 1);
  localparam int DW   = $clog2(DEBT_MAX + 1);

  logic [TW-1:0] timer, loadVal;
  logic [IW-1:0] intCnt;
  logic [BW-1:0] burstCnt;
  logic [DW-1:0] debt;
  logic          tick;

  always_comb begin
    case (stb.ldSel)
      S_CSET:   loadVal = TW'(CSR_C - 1);
      S_RLOW:   loadVal = TW'(RASL_C - 1);
      S_PRE:    loadVal = TW'(PRE_C - 1);
      S_SRHOLD: loadVal = TW'(RASS_C - 1);
      S_SREXIT: loadVal = TW'(RPS_C - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= TW'(PWR_C - 1);
    else if (stb.ldTimer)    timer <= loadVal;
    else if (timer != '0)    timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 burstCnt <= '0;
    else if (stb.ldBurstFull)  burstCnt <= BW'(WAKE_CNT);
    else if (stb.ldBurstOne)   burstCnt <= BW'(1);
    else if (stb.decBurst)     burstCnt <= burstCnt - 1'b1;
  end

  assign tick = stb.runInt && !stb.rstInt && (intCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || !stb.runInt || stb.rstInt) intCnt <= IW'(INT_C - 1);
    else if (intCnt == '0)                  intCnt <= IW'(INT_C - 1);
    else                                    intCnt <= intCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrDebt) debt <= '0;
    else begin
      case ({tick && (debt != DW'(DEBT_MAX)), stb.decDebt && (debt != '0)})
        2'b10:   debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign sts.timerDone = (timer == '0);
  assign sts.chrActive = (int'(timer) + CHR_C) >= RASL_C;
  assign sts.burstLast = (burstCnt == BW'(1));
  assign sts.debtNz    = (debt != '0);
  assign sts.debtFull  = (debt == DW'(DEBT_MAX));

  // strobes decoded from the registered state
  assign rasN  = !((state == S_RLOW) || (state == S_SRHOLD));
  assign casLN = !((state == S_CSET) || (state == S_SRHOLD) || ((state == S_RLOW) && sts.chrActive));
  assign casHN = casLN;
  assign weN   = 1'b1;

endmodule

// File: rtl/dram_ref_ctrl.sv
module dram_ref_ctrl
  import dram_ref_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refGrant,
  input  logic    pageClosed,
  input  logic    selfRefReq,
  input  status_t sts,
  output strobe_t stb,
  output state_t  state,
  output logic    ready,
  output logic    refReq,
  output logic    refUrgent,
  output logic    busOwned,
  output logic    inSelfRef
);
  state_t stateNx;
  logic   readyQ, readyNx, fullBurst, fullNx, srPend, srNx;

  assign refReq    = readyQ && (state == S_IDLE) && (sts.debtNz || selfRefReq);
  assign refUrgent = readyQ && sts.debtFull;
  assign busOwned  = (state != S_IDLE) && (state != S_PWR);
  assign inSelfRef = (state == S_SRHOLD) && sts.timerDone;
  assign ready     = readyQ;

  always_comb begin
    stateNx = state;
    readyNx = readyQ;
    fullNx  = fullBurst;
    srNx    = srPend;
    stb     = '0;
    stb.runInt = readyQ;
    case (state)
      S_PWR: if (sts.timerDone) begin
        stateNx = S_CSET; stb.ldTimer = 1'b1; stb.ldBurstFull = 1'b1; fullNx = 1'b1;
      end
      S_IDLE: if (refReq && refGrant && pageClosed) begin
        stateNx = S_CSET; stb.ldTimer = 1'b1;
        if (selfRefReq) srNx = 1'b1;
        else begin stb.ldBurstOne = 1'b1; fullNx = 1'b0; end
      end
      S_CSET: if (sts.timerDone) begin
        stateNx = srPend ? S_SRHOLD : S_RLOW; stb.ldTimer = 1'b1;
      end
      S_RLOW: if (sts.timerDone) begin
        stateNx = S_PRE; stb.ldTimer = 1'b1;
      end
      S_PRE: if (sts.timerDone) begin
        if (sts.burstLast) begin
          stateNx = S_IDLE;
          if (fullBurst) begin stb.clrDebt = 1'b1; stb.rstInt = 1'b1; readyNx = 1'b1; end
          else stb.decDebt = 1'b1;
        end else begin
          stb.decBurst = 1'b1; stateNx = S_CSET; stb.ldTimer = 1'b1;
        end
      end
      S_SRHOLD: if (sts.timerDone && !selfRefReq) begin
        stateNx = S_SREXIT; stb.ldTimer = 1'b1; srNx = 1'b0;
      end
      S_SREXIT: if (sts.timerDone) begin
        stateNx = S_CSET; stb.ldTimer = 1'b1; stb.ldBurstFull = 1'b1; fullNx = 1'b1;
      end
      default: stateNx = S_IDLE;
    endcase
    stb.ldSel = stateNx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_PWR; readyQ <= 1'b0; fullBurst <= 1'b1; srPend <= 1'b0;
    end else begin
      state <= stateNx; readyQ <= readyNx; fullBurst <= fullNx; srPend <= srNx;
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int T_PWRUP_NS = 100000,
  parameter int T_INT_NS   = 15600,
  parameter int T_CSR_NS   = 5,
  parameter int T_CHR_NS   = 8,
  parameter int T_RAS_NS   = 50,
  parameter int T_RP_NS    = 30,
  parameter int T_RC_NS    = 84,
  parameter int T_RASS_NS  = 100000,
  parameter int T_RPS_NS   = 90,
  parameter int WAKE_CNT   = 8,
  parameter int DEBT_MAX   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  input  logic pageClosed,
  input  logic selfRefReq,
  output logic refReq,
  output logic refUrgent,
  output logic busOwned,
  output logic ready,
  output logic inSelfRef,
  output logic rasN,
  output logic casLN,
  output logic casHN,
  output logic weN
);
  localparam int PWR_C  = nsToCyc(T_PWRUP_NS, CLK_NS);
  localparam int INT_C  = nsToCyc(T_INT_NS, CLK_NS);
  localparam int CSR_C  = nsToCyc(T_CSR_NS, CLK_NS);
  localparam int CHR_C  = nsToCyc(T_CHR_NS, CLK_NS);
  localparam int RAS_C  = nsToCyc(T_RAS_NS, CLK_NS);
  localparam int RP_C   = nsToCyc(T_RP_NS, CLK_NS);
  localparam int RC_C   = nsToCyc(T_RC_NS, CLK_NS);
  localparam int RASS_C = nsToCyc(T_RASS_NS, CLK_NS);
  localparam int RPS_C  = nsToCyc(T_RPS_NS, CLK_NS);
  localparam int RASL_C = maxOf(RAS_C, CHR_C);
  localparam int PRE_C  = maxOf(RP_C, RC_C - RASL_C);

  strobe_t stb;
  status_t sts;
  state_t  state;

  dram_ref_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .pageClosed(pageClosed),
    .selfRefReq(selfRefReq), .sts(sts), .stb(stb), .state(state),
    .ready(ready), .refReq(refReq), .refUrgent(refUrgent),
    .busOwned(busOwned), .inSelfRef(inSelfRef)
  );

  dram_ref_dp #(
    .PWR_C(PWR_C), .CSR_C(CSR_C), .RASL_C(RASL_C), .CHR_C(CHR_C), .PRE_C(PRE_C),
    .RASS_C(RASS_C), .RPS_C(RPS_C), .INT_C(INT_C), .WAKE_CNT(WAKE_CNT), .DEBT_MAX(DEBT_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .state(state), .sts(sts),
    .rasN(rasN), .casLN(casLN), .casHN(casHN), .weN(weN)
  );

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int RASL_C = 5,
  parameter int PRE_C  = 4,
  parameter int RC_C   = 9
) (
  input logic clk,
  input logic rstN,
  input logic refGrant,
  input logic pageClosed,
  input logic refReq,
  input logic refUrgent,
  input logic busOwned,
  input logic ready,
  input logic inSelfRef,
  input logic rasN,
  input logic casLN,
  input logic casHN,
  input logic weN
);
  int lowCnt, hiCnt, sinceFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= 0; hiCnt <= 0; sinceFall <= RC_C;
    end else begin
      lowCnt    <= rasN ? 0 : lowCnt + 1;
      hiCnt     <= rasN ? hiCnt + 1 : 0;
      sinceFall <= (!rasN && lowCnt == 0) ? 1 : sinceFall + 1;
    end
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    !busOwned |-> (rasN && casLN && casHN));
  a_r2_no_req_early: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (!refReq && !refUrgent));
  a_r3_cas_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(!casLN && !casHN) && !casLN && !casHN && weN));
  a_r4_ras_low_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowCnt >= RASL_C));
  a_r4_precharge_min: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (hiCnt >= PRE_C && sinceFall >= RC_C));
  a_r6_grant_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busOwned) && $past(ready)) |-> $past(refGrant && pageClosed));
  a_r8_strobes_low: assert property (@(posedge clk) disable iff (!rstN)
    inSelfRef |-> (!rasN && !casLN && !casHN));
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .RASL_C(RASL_C), .PRE_C(PRE_C), .RC_C(RC_C)
) u_chk (
  .clk(clk), .rstN(rstN), .refGrant(refGrant), .pageClosed(pageClosed),
  .refReq(refReq), .refUrgent(refUrgent), .busOwned(busOwned), .ready(ready),
  .inSelfRef(inSelfRef), .rasN(rasN), .casLN(casLN), .casHN(casHN), .weN(weN)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  // cycle counts at 10 ns from the bench parameters below
  localparam int PWR_C  = 200;  // 2000 ns
  localparam int INT_C  = 200;  // 2000 ns
  localparam int RASS_C = 100;  // 1000 ns
  localparam int RPS_C  = 9;    // 90 ns
  localparam int RASL_C = 5;    // max(50,8) ns
  localparam int PRE_C  = 4;    // max(30, 84-50) ns
  localparam int WAKE   = 8;
  localparam int DMAX   = 8;

  logic clk = 0, rstN = 0, refGrant = 0, pageClosed = 0, selfRefReq = 0;
  logic refReq, refUrgent, busOwned, ready, inSelfRef, rasN, casLN, casHN, weN;

  dram_refresh_sched #(
    .CLK_NS(10), .T_PWRUP_NS(2000), .T_INT_NS(2000), .T_RASS_NS(1000)
  ) u_dram_refresh_sched (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .pageClosed(pageClosed),
    .selfRefReq(selfRefReq), .refReq(refReq), .refUrgent(refUrgent),
    .busOwned(busOwned), .ready(ready), .inSelfRef(inSelfRef),
    .rasN(rasN), .casLN(casLN), .casHN(casHN), .weN(weN)
  );

  always #5 clk = ~clk;

  typedef struct { int minHi; int minLow; string tag; } exp_t;
  exp_t expQ[$];
  exp_t cur;
  int nChk = 0, nBad = 0, cyc = 0, nFalls = 0;
  int lowRun = 0, hiRun = 0;
  logic prevRas = 1, prevCas = 1;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectCbr(int n, int minHi, int minLow, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.minHi = minHi; e.minLow = minLow; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops one expected entry per RAS# fall and compares
  always @(negedge clk) begin
    if (!rstN) begin
      prevRas = 1; prevCas = 1; lowRun = 0; hiRun = 0;
    end else begin
      if (prevRas && !rasN) begin
        nFalls++;
        if (expQ.size() == 0) chk(0, "R6 unexpected refresh", nFalls, 0);
        else begin
          cur = expQ.pop_front();
          chk(!prevCas && !casLN && !casHN, {cur.tag, " R3 cas before ras"}, int'(casLN), 0);
          chk(weN == 1'b1, {cur.tag, " R3 we high"}, int'(weN), 1);
          chk(hiRun >= cur.minHi, {cur.tag, " R4 high time"}, hiRun, cur.minHi);
        end
      end
      if (!prevRas && rasN)
        chk(lowRun >= cur.minLow, {cur.tag, " R4 low time"}, lowRun, cur.minLow);
      if (rasN) begin hiRun++; lowRun = 0; end
      else begin lowRun++; hiRun = 0; end
      prevRas = rasN; prevCas = casLN;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      summary();
    end
  end

  initial begin
    int t0, d, tReq, tS, falls0, guard;
    step(5);
    // R1 reset state
    chk(ready == 0 && refReq == 0 && refUrgent == 0, "R1 flags in reset", int'(ready), 0);
    chk(rasN && casLN && casHN && !busOwned, "R1 pins idle in reset", int'(rasN), 1);
    expectCbr(1, PWR_C, RASL_C, "R1");
    expectCbr(WAKE - 1, PRE_C, RASL_C, "R2");
    rstN = 1;
    step(50);
    chk(nFalls == 0 && refReq == 0, "R1 no refresh during wait", nFalls, 0);
    guard = 0;
    while (!ready && guard < 2000) begin
      chk(refReq == 0, "R2 no req before ready", int'(refReq), 0);
      step(); guard++;
    end
    chk(ready == 1, "R2 ready after wake-up", int'(ready), 1);
    chk(nFalls == WAKE && expQ.size() == 0, "R2 wake-up count", nFalls, WAKE);

    // R5 first owed refresh
    t0 = cyc; guard = 0;
    while (!refReq && guard < 1000) begin step(); guard++; end
    d = cyc - t0; tReq = cyc;
    chk(d >= INT_C - 2 && d <= INT_C + 2, "R5 interval", d, INT_C);
    chk(refUrgent == 0, "R7 not urgent at debt one", int'(refUrgent), 0);

    // R6 grant with page open
    refGrant = 1; pageClosed = 0;
    step(20);
    chk(busOwned == 0 && nFalls == WAKE, "R6 open page blocks", int'(busOwned), 0);
    expectCbr(1, PRE_C, RASL_C, "R6");
    pageClosed = 1;
    guard = 0;
    while (!busOwned && guard < 50) begin step(); guard++; end
    refGrant = 0;
    guard = 0;
    while (busOwned && guard < 100) begin step(); guard++; end
    step();
    chk(refReq == 0 && expQ.size() == 0, "R6 one refresh pays debt", int'(refReq), 0);

    // R7 saturation
    while (cyc < tReq + 7 * INT_C + 5) step();
    chk(refUrgent == 0, "R7 debt seven not urgent", int'(refUrgent), 0);
    while (cyc < tReq + 8 * INT_C + 5) step();
    chk(refUrgent == 1, "R7 urgent at limit", int'(refUrgent), 1);
    while (cyc < tReq + 10 * INT_C + 5) step();
    chk(refUrgent == 1, "R7 still urgent", int'(refUrgent), 1);
    falls0 = nFalls;
    expectCbr(DMAX, PRE_C, RASL_C, "R7");
    refGrant = 1;
    step(2);
    guard = 0;
    while ((refReq || busOwned) && guard < 400) begin step(); guard++; end
    refGrant = 0;
    step(2);
    chk(nFalls - falls0 == DMAX, "R7 drain count", nFalls - falls0, DMAX);
    chk(refUrgent == 0 && expQ.size() == 0, "R7 drained", int'(refUrgent), 0);

    // R8 self refresh entry
    selfRefReq = 1;
    step();
    chk(refReq == 1, "R8 request for self refresh", int'(refReq), 1);
    expectCbr(1, PRE_C, RASS_C, "R8");
    expectCbr(1, RPS_C, RASL_C, "R9");
    expectCbr(WAKE - 1, PRE_C, RASL_C, "R9");
    refGrant = 1;
    guard = 0;
    while (!busOwned && guard < 50) begin step(); guard++; end
    refGrant = 0;
    tS = cyc; guard = 0;
    while (!inSelfRef && guard < 1000) begin step(); guard++; end
    chk(cyc - tS >= RASS_C, "R8 self refresh delay", cyc - tS, RASS_C);
    chk(!rasN && !casLN && !casHN, "R8 strobes low", int'(rasN), 0);
    falls0 = nFalls;
    step(50);
    chk(inSelfRef == 1 && nFalls == falls0, "R8 held", int'(inSelfRef), 1);

    // R9 exit and catch-up
    selfRefReq = 0;
    guard = 0;
    while (busOwned && guard < 1000) begin step(); guard++; end
    step();
    chk(expQ.size() == 0 && nFalls - falls0 == WAKE, "R9 catch-up burst", nFalls - falls0, WAKE);
    chk(inSelfRef == 0 && refReq == 0, "R9 debt cleared", int'(refReq), 0);
    chk(ready == 1, "R10 ready kept", int'(ready), 1);
    step(20);
    chk(nFalls - falls0 == WAKE, "R9 no extra refresh", nFalls - falls0, WAKE);
    done = 1;
    summary();
  end

endmodule